// File: doc/BRIEF.md
# Maintenance Response Error Tracker

This block sits behind a memory-mapped port that turns reads and writes into serial-interconnect MAINTENANCE requests. It keeps a small table of outstanding requests indexed by transaction tag, runs a response timer for each one, and checks every returned response against that table. Each anomaly is sorted into one of four error classes: IO error, unsolicited response, response timeout and illegal decode. Each class sets a sticky detect bit, and the header fields of the first offending packet are held until software clears the detect bits.

The address-window decode is done outside the block, which receives only a hit/miss indication with each request. A request that misses every window is not tracked. It sets a sticky out-of-window status bit, one for reads and one for writes, and that bit can raise the interrupt output through an enable mask. For reads, the block also produces a completion pulse with an error flag back to the port. The flag is set for an ERROR response, for a read timeout and for an out-of-window read.

Top module: `mrt_top`

## Requirements
- R1: A request with `req_hit`=1 records its tag as pending. A later response on that tag with status DONE (4'h0) and a legal type (4'h2 with `rsp_words`=1 for a read, 4'h3 with `rsp_words`=0 for a write) frees the tag and sets no error bit. For a read, `rd_done`=1 and `rd_err`=0 for the one cycle after the response edge.
- R2: A legal response with status ERROR (4'h7) to a pending tag sets `err_flags[0]`. If the tag was a read, `rd_done` and `rd_err` are both 1 for the cycle after the response edge.
- R3: A response whose tag is not pending sets `err_flags[1]` and gives no `rd_done` pulse.
- R4: Take the issue edge as edge 0 and the `rsp_timeout` value as L (nonzero). A pending tag with no response by edge L sets `err_flags[2]` at edge L and frees the tag. A response at edge L is still accepted. A read that times out pulses `rd_done` and `rd_err`. A later response to the freed tag is handled as in R3.
- R5: A response to a pending tag with a status other than 4'h0 or 4'h7 sets `err_flags[3]`.
- R6: A response to a pending tag sets `err_flags[3]` when `rsp_words`≠0 and the type is not 4'h2, or when `rsp_words`=0 and the type is not 4'h3.
- R7: A response to a pending read that carries more than one 32-bit word (`rsp_words`>1) sets `err_flags[3]`.
- R8: A request with `req_hit`=0 is not tracked. It sets `oob_flags[0]` for a read or `oob_flags[1]` for a write. An out-of-window read pulses `rd_done` and `rd_err` in the cycle after the request edge.
- R9: `irq` equals the OR of (`oob_flags` AND `oob_irq_en`). Writing 1 to a bit of `oob_clr` clears that status bit. Status bits are otherwise sticky.
- R10: `err_flags` bits are sticky and cleared only by writing 1 to `err_clr`. When an error is detected while no `err_flags` bit is set, `cap_ttype`, `cap_tag` and `cap_status` capture that error's type, tag and status. For a timeout the captured type is 4'h0 (read) or 4'h1 (write) and the status is 0. The capture stays frozen while any `err_flags` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request issued this cycle |
| req_write | input | 1 | 1 = write request, 0 = read |
| req_tag | input | 2 | Transaction tag of the request |
| req_hit | input | 1 | Address hit an enabled window |
| rsp_valid | input | 1 | Response received this cycle |
| rsp_ttype | input | 4 | Response transaction type |
| rsp_tag | input | 2 | Response transaction tag |
| rsp_status | input | 4 | Response status code |
| rsp_words | input | 3 | Payload length in 32-bit words |
| rsp_timeout | input | 16 | Response timeout in cycles |
| err_clr | input | 4 | Write-1-to-clear for error detect bits |
| oob_clr | input | 2 | Write-1-to-clear for out-of-window bits |
| oob_irq_en | input | 2 | Interrupt enable per out-of-window bit |
| err_flags | output | 4 | Sticky error detect bits |
| cap_ttype | output | 4 | Captured type of the first error |
| cap_tag | output | 2 | Captured tag of the first error |
| cap_status | output | 4 | Captured status of the first error |
| oob_flags | output | 2 | Sticky out-of-window status |
| irq | output | 1 | Interrupt output |
| rd_done | output | 1 | Read completion pulse |
| rd_err | output | 1 | Read completed with error |

## Verification
Every response, request and clear is sampled on one clock edge. All flags, captures and read pulses are registered, so they are visible one edge later. The interrupt is combinational from the status register, so it follows that same edge. A timeout lands exactly L edges after the issue edge. The bench drives stimulus on the falling edge, lets one rising edge pass, and samples on the next falling edge. The timeout test checks that nothing is flagged after edge L-1 and that the flag is present after edge L.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam logic [3:0] TT_RD_REQ = 4'h0;
  localparam logic [3:0] TT_WR_REQ = 4'h1;
  localparam logic [3:0] TT_RD_RSP = 4'h2;
  localparam logic [3:0] TT_WR_RSP = 4'h3;
  localparam logic [3:0] ST_DONE   = 4'h0;
  localparam logic [3:0] ST_ERROR  = 4'h7;
  localparam int ERR_IO    = 0;
  localparam int ERR_UNSOL = 1;
  localparam int ERR_TMO   = 2;
  localparam int ERR_ILL   = 3;
  localparam int NERR      = 4;
endpackage

// File: rtl/mrt_pend_table.sv
module mrt_pend_table #(
  parameter int NTAG = 4,
  parameter int TW   = 16,
  localparam int TAGW = $clog2(NTAG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_en,
  input  logic [TAGW-1:0] alloc_tag,
  input  logic            alloc_wr,
  input  logic            rsp_free,
  input  logic [TAGW-1:0] rsp_tag,
  input  logic [TW-1:0]   limit,
  output logic [NTAG-1:0] pend,
  output logic [NTAG-1:0] is_wr,
  output logic [NTAG-1:0] expire
);
  for (genvar g = 0; g < NTAG; g++) begin : g_slot
    logic          busy_q, busy_d, wr_q, wr_d, take, answered, cnt_en;
    logic [TW-1:0] cnt_q, cnt_d;

    always_comb begin
      take      = alloc_en && (alloc_tag == TAGW'(g));
      answered  = rsp_free && (rsp_tag == TAGW'(g));
      expire[g] = busy_q && !answered && (cnt_q == limit - TW'(1));
      busy_d    = take ? 1'b1 : (busy_q && !answered && !expire[g]);
      wr_d      = take ? alloc_wr : wr_q;
      cnt_en    = take || busy_q;
      cnt_d     = take ? '0 : cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        wr_q   <= 1'b0;
        cnt_q  <= '0;
      end else begin
        busy_q <= busy_d;
        wr_q   <= wr_d;
        if (cnt_en) cnt_q <= cnt_d;
      end
    end

    assign pend[g]  = busy_q;
    assign is_wr[g] = wr_q;

    // R4: a pending timer never runs past the programmed limit
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && limit != '0 && $stable(limit)) |-> (cnt_q < limit));
  end
endmodule

// File: rtl/mrt_rsp_class.sv
module mrt_rsp_class
  import mrt_pkg::*;
#(
  parameter int NTAG = 4,
  localparam int TAGW = $clog2(NTAG)
) (
  input  logic            rsp_valid,
  input  logic [3:0]      rsp_ttype,
  input  logic [TAGW-1:0] rsp_tag,
  input  logic [3:0]      rsp_status,
  input  logic [2:0]      rsp_words,
  input  logic [NTAG-1:0] pend,
  input  logic [NTAG-1:0] is_wr,
  output logic            hit,
  output logic            unsol,
  output logic            illegal,
  output logic            ioerr,
  output logic            rd_fin,
  output logic            rd_bad
);
  logic bad_stat, bad_type, too_long;

  always_comb begin
    hit      = rsp_valid && pend[rsp_tag];
    unsol    = rsp_valid && !pend[rsp_tag];
    bad_stat = (rsp_status != ST_DONE) && (rsp_status != ST_ERROR);
    bad_type = (rsp_words != 3'd0) ? (rsp_ttype != TT_RD_RSP) : (rsp_ttype != TT_WR_RSP);
    too_long = !is_wr[rsp_tag] && (rsp_words > 3'd1);
    illegal  = hit && (bad_stat || bad_type || too_long);
    ioerr    = hit && !illegal && (rsp_status == ST_ERROR);
    rd_fin   = hit && !is_wr[rsp_tag];
    rd_bad   = rd_fin && (rsp_status == ST_ERROR);
  end
endmodule

// File: rtl/mrt_err_regs.sv
module mrt_err_regs
  import mrt_pkg::*;
#(
  parameter int NTAG = 4,
  localparam int TAGW = $clog2(NTAG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NERR-1:0] ev,
  input  logic [NERR-1:0] clr,
  input  logic [3:0]      in_ttype,
  input  logic [TAGW-1:0] in_tag,
  input  logic [3:0]      in_status,
  output logic [NERR-1:0] flags,
  output logic [3:0]      cap_ttype,
  output logic [TAGW-1:0] cap_tag,
  output logic [3:0]      cap_status
);
  logic [NERR-1:0] err_q, err_d;
  logic            cap_en;
  logic [3:0]      ttype_q, status_q;
  logic [TAGW-1:0] tag_q;

  always_comb begin
    err_d  = (err_q & ~clr) | ev;
    cap_en = (ev != '0) && (err_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= '0;
      ttype_q  <= '0;
      tag_q    <= '0;
      status_q <= '0;
    end else begin
      err_q <= err_d;
      if (cap_en) begin
        ttype_q  <= in_ttype;
        tag_q    <= in_tag;
        status_q <= in_status;
      end
    end
  end

  assign flags      = err_q;
  assign cap_ttype  = ttype_q;
  assign cap_tag    = tag_q;
  assign cap_status = status_q;

  // R10: a detect bit only drops after a write-1 clear
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_q) & ~err_q & ~$past(clr)) == '0);
  // R10: capture frozen while an error was already recorded
  assert_cap_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|$past(err_q)) |-> ($stable(ttype_q) && $stable(tag_q) && $stable(status_q)));
endmodule

// File: rtl/mrt_top.sv
module mrt_top
  import mrt_pkg::*;
#(
  parameter int NTAG = 4,
  parameter int TW   = 16,
  localparam int TAGW = $clog2(NTAG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [TAGW-1:0] req_tag,
  input  logic            req_hit,
  input  logic            rsp_valid,
  input  logic [3:0]      rsp_ttype,
  input  logic [TAGW-1:0] rsp_tag,
  input  logic [3:0]      rsp_status,
  input  logic [2:0]      rsp_words,
  input  logic [TW-1:0]   rsp_timeout,
  input  logic [NERR-1:0] err_clr,
  input  logic [1:0]      oob_clr,
  input  logic [1:0]      oob_irq_en,
  output logic [NERR-1:0] err_flags,
  output logic [3:0]      cap_ttype,
  output logic [TAGW-1:0] cap_tag,
  output logic [3:0]      cap_status,
  output logic [1:0]      oob_flags,
  output logic            irq,
  output logic            rd_done,
  output logic            rd_err
);
  logic [NTAG-1:0] pend, is_wr, expire;
  logic            hit, unsol, illegal, ioerr, rd_fin, rd_bad;
  logic            to_any, to_wr, to_rd_any, miss, miss_rd;
  logic [TAGW-1:0] to_tag;
  logic [NERR-1:0] ev;
  logic [3:0]      src_ttype, src_status;
  logic [TAGW-1:0] src_tag;
  logic [1:0]      oob_q, oob_d;
  logic            rd_done_q, rd_done_d, rd_err_q, rd_err_d;

  mrt_pend_table #(.NTAG(NTAG), .TW(TW)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(req_valid && req_hit), .alloc_tag(req_tag), .alloc_wr(req_write),
    .rsp_free(hit), .rsp_tag(rsp_tag), .limit(rsp_timeout),
    .pend(pend), .is_wr(is_wr), .expire(expire));

  mrt_rsp_class #(.NTAG(NTAG)) u_class (
    .rsp_valid(rsp_valid), .rsp_ttype(rsp_ttype), .rsp_tag(rsp_tag),
    .rsp_status(rsp_status), .rsp_words(rsp_words), .pend(pend), .is_wr(is_wr),
    .hit(hit), .unsol(unsol), .illegal(illegal), .ioerr(ioerr),
    .rd_fin(rd_fin), .rd_bad(rd_bad));

  // lowest expiring tag supplies the capture fields for a timeout
  always_comb begin
    to_any = 1'b0;
    to_wr  = 1'b0;
    to_tag = '0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (expire[i]) begin
        to_any = 1'b1;
        to_wr  = is_wr[i];
        to_tag = TAGW'(i);
      end
    end
    to_rd_any = |(expire & ~is_wr);
  end

  always_comb begin
    ev            = '0;
    ev[ERR_IO]    = ioerr;
    ev[ERR_UNSOL] = unsol;
    ev[ERR_TMO]   = to_any;
    ev[ERR_ILL]   = illegal;
    if (unsol || illegal || ioerr) begin
      src_ttype  = rsp_ttype;
      src_tag    = rsp_tag;
      src_status = rsp_status;
    end else begin
      src_ttype  = to_wr ? TT_WR_REQ : TT_RD_REQ;
      src_tag    = to_tag;
      src_status = 4'h0;
    end
  end

  mrt_err_regs #(.NTAG(NTAG)) u_err (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr(err_clr),
    .in_ttype(src_ttype), .in_tag(src_tag), .in_status(src_status),
    .flags(err_flags), .cap_ttype(cap_ttype), .cap_tag(cap_tag),
    .cap_status(cap_status));

  always_comb begin
    miss      = req_valid && !req_hit;
    miss_rd   = miss && !req_write;
    oob_d     = (oob_q & ~oob_clr) | {miss && req_write, miss_rd};
    rd_done_d = rd_fin || to_rd_any || miss_rd;
    rd_err_d  = rd_bad || to_rd_any || miss_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oob_q     <= '0;
      rd_done_q <= 1'b0;
      rd_err_q  <= 1'b0;
    end else begin
      oob_q     <= oob_d;
      rd_done_q <= rd_done_d;
      rd_err_q  <= rd_err_d;
    end
  end

  assign oob_flags = oob_q;
  assign irq       = |(oob_q & oob_irq_en);
  assign rd_done   = rd_done_q;
  assign rd_err    = rd_err_q;

  // R2: an error flag on the read port always comes with a completion
  assert_rderr_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_done);
  // R1: a completion follows a request, a response or a pending read
  assert_done_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $past(req_valid || rsp_valid || (pend != '0)));
  // R8: out-of-window status drops only after a clear
  assert_oob_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(oob_q) & ~oob_q & ~$past(oob_clr)) == '0);
  // R3: an unsolicited response never completes a read
  assert_unsol_nodone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unsol && !req_valid && pend == '0) |=> !rd_done);
endmodule

// File: tb/mrt_top_tb_top.sv
`timescale 1ns/1ps
module mrt_top_tb_top;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_hit;
  logic [1:0] req_tag;
  logic rsp_valid;
  logic [3:0] rsp_ttype, rsp_status;
  logic [1:0] rsp_tag;
  logic [2:0] rsp_words;
  logic [15:0] rsp_timeout;
  logic [3:0] err_clr;
  logic [1:0] oob_clr, oob_irq_en;
  logic [3:0] err_flags, cap_ttype, cap_status;
  logic [1:0] cap_tag, oob_flags;
  logic irq, rd_done, rd_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mrt_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_tag(req_tag), .req_hit(req_hit), .rsp_valid(rsp_valid),
    .rsp_ttype(rsp_ttype), .rsp_tag(rsp_tag), .rsp_status(rsp_status),
    .rsp_words(rsp_words), .rsp_timeout(rsp_timeout), .err_clr(err_clr),
    .oob_clr(oob_clr), .oob_irq_en(oob_irq_en), .err_flags(err_flags),
    .cap_ttype(cap_ttype), .cap_tag(cap_tag), .cap_status(cap_status),
    .oob_flags(oob_flags), .irq(irq), .rd_done(rd_done), .rd_err(rd_err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic wr, input logic [1:0] tag, input logic hit);
    req_valid = 1'b1; req_write = wr; req_tag = tag; req_hit = hit;
    step();
    req_valid = 1'b0;
  endtask

  task automatic respond(input logic [1:0] tag, input logic [3:0] tt,
                         input logic [3:0] st, input logic [2:0] words);
    rsp_valid = 1'b1; rsp_tag = tag; rsp_ttype = tt; rsp_status = st; rsp_words = words;
    step();
    rsp_valid = 1'b0;
  endtask

  task automatic clear_all();
    err_clr = 4'hF; oob_clr = 2'b11;
    step();
    err_clr = 4'h0; oob_clr = 2'b00;
  endtask

  task automatic t_reset();
    check("R10 reset flags", {28'd0, err_flags}, 0);
    check("R8 reset oob", {30'd0, oob_flags}, 0);
    check("R1 reset rd_done", {31'd0, rd_done}, 0);
  endtask

  task automatic t_good();
    clear_all();
    issue(1'b0, 2'd0, 1'b1);
    issue(1'b1, 2'd1, 1'b1);
    respond(2'd0, 4'h2, 4'h0, 3'd1);
    check("R1 read done", {30'd0, rd_done, rd_err}, 2'b10);
    respond(2'd1, 4'h3, 4'h0, 3'd0);
    check("R1 write no rd_done", {31'd0, rd_done}, 0);
    check("R1 no error", {28'd0, err_flags}, 0);
  endtask

  task automatic t_ioerr();
    clear_all();
    issue(1'b0, 2'd2, 1'b1);
    respond(2'd2, 4'h2, 4'h7, 3'd1);
    check("R2 io flag", {28'd0, err_flags}, 4'b0001);
    check("R2 rd_err", {30'd0, rd_done, rd_err}, 2'b11);
    check("R10 cap", {20'd0, cap_ttype, 2'b00, cap_tag, cap_status}, {20'd0, 4'h2, 2'b00, 2'd2, 4'h7});
  endtask

  task automatic t_unsol();
    clear_all();
    respond(2'd3, 4'h2, 4'h0, 3'd1);
    check("R3 unsol flag", {28'd0, err_flags}, 4'b0010);
    check("R3 no rd_done", {31'd0, rd_done}, 0);
  endtask

  task automatic t_timeout();
    clear_all();
    issue(1'b0, 2'd2, 1'b1);
    for (int k = 1; k < L; k++) step();
    check("R4 not yet", {28'd0, err_flags}, 0);
    step();
    check("R4 timeout flag", {28'd0, err_flags}, 4'b0100);
    check("R4 read pulse", {30'd0, rd_done, rd_err}, 2'b11);
    check("R10 timeout cap", {20'd0, cap_ttype, 2'b00, cap_tag, cap_status}, {20'd0, 4'h0, 2'b00, 2'd2, 4'h0});
    clear_all();
    respond(2'd2, 4'h2, 4'h0, 3'd1);
    check("R4 late response unsolicited", {28'd0, err_flags}, 4'b0010);
    // response exactly at edge L is accepted
    clear_all();
    issue(1'b1, 2'd1, 1'b1);
    for (int k = 1; k < L; k++) step();
    respond(2'd1, 4'h3, 4'h0, 3'd0);
    check("R4 response at limit accepted", {28'd0, err_flags}, 0);
  endtask

  task automatic t_illegal();
    clear_all();
    issue(1'b1, 2'd0, 1'b1);
    respond(2'd0, 4'h3, 4'h5, 3'd0);
    check("R5 bad status", {28'd0, err_flags}, 4'b1000);
    clear_all();
    issue(1'b1, 2'd1, 1'b1);
    respond(2'd1, 4'h3, 4'h0, 3'd1);
    check("R6 payload with write type", {28'd0, err_flags}, 4'b1000);
    clear_all();
    issue(1'b0, 2'd3, 1'b1);
    respond(2'd3, 4'h2, 4'h0, 3'd0);
    check("R6 no payload read type", {28'd0, err_flags}, 4'b1000);
    clear_all();
    issue(1'b0, 2'd2, 1'b1);
    respond(2'd2, 4'h2, 4'h0, 3'd2);
    check("R7 long read", {28'd0, err_flags}, 4'b1000);
  endtask

  task automatic t_oob();
    clear_all();
    oob_irq_en = 2'b00;
    issue(1'b1, 2'd0, 1'b0);
    check("R8 write oob", {30'd0, oob_flags}, 2'b10);
    check("R8 write no rd_done", {31'd0, rd_done}, 0);
    check("R9 irq masked", {31'd0, irq}, 0);
    oob_irq_en = 2'b10;
    #1;
    check("R9 irq enabled", {31'd0, irq}, 1);
    oob_clr = 2'b10;
    step();
    oob_clr = 2'b00;
    check("R9 w1c clears", {30'd0, oob_flags, irq}, 0);
    issue(1'b0, 2'd3, 1'b0);
    check("R8 read oob", {30'd0, oob_flags}, 2'b01);
    check("R8 read pulse", {30'd0, rd_done, rd_err}, 2'b11);
    check("R9 irq other bit masked", {31'd0, irq}, 0);
    step();
    check("R8 oob sticky", {30'd0, oob_flags}, 2'b01);
    respond(2'd3, 4'h2, 4'h0, 3'd1);
    check("R8 miss not tracked", {28'd0, err_flags}, 4'b0010);
    oob_irq_en = 2'b00;
  endtask

  task automatic t_capture();
    clear_all();
    respond(2'd1, 4'h3, 4'h0, 3'd0);
    issue(1'b1, 2'd0, 1'b1);
    respond(2'd0, 4'h3, 4'h5, 3'd0);
    check("R10 two flags", {28'd0, err_flags}, 4'b1010);
    check("R10 first capture held", {20'd0, cap_ttype, 2'b00, cap_tag, cap_status}, {20'd0, 4'h3, 2'b00, 2'd1, 4'h0});
    err_clr = 4'b0010;
    step();
    err_clr = 4'h0;
    check("R10 partial clear", {28'd0, err_flags}, 4'b1000);
    clear_all();
    respond(2'd2, 4'h2, 4'h7, 3'd1);
    check("R10 recapture", {20'd0, cap_ttype, 2'b00, cap_tag, cap_status}, {20'd0, 4'h2, 2'b00, 2'd2, 4'h7});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_tag = 0; req_hit = 0;
    rsp_valid = 0; rsp_ttype = 0; rsp_tag = 0; rsp_status = 0; rsp_words = 0;
    rsp_timeout = 16'(L); err_clr = 0; oob_clr = 0; oob_irq_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_good();
    t_ioerr();
    t_unsol();
    t_timeout();
    t_illegal();
    t_oob();
    t_capture();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule